// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block drains a circular ring of transmit descriptors kept in a synchronous word-wide memory. A host fills descriptors, hands each one to the engine by setting its ownership bit, and pulses a demand input. The engine then polls the current slot. For every slot it owns, it reads the buffer location and the byte count, streams exactly that many bytes over a byte-wide valid/ready port, and waits for the downstream MAC to report completion. It then writes the per-frame status back into the descriptor and returns the slot to the host.

After writing a slot back, the engine moves to the next index, wrapping at the ring size, and continues for as long as it keeps finding slots it owns. When it reaches a slot the host still holds, it goes idle until the next demand. Both memory writes for a slot go out in a fixed order: the status word first, then the flag word that releases ownership. This lets the host treat a cleared ownership bit as proof that the status word is already valid.

Top module: `txring_engine`

## Requirements
- R1: A descriptor is four consecutive memory words at word address ringBase + 4*index. Word 0 holds the low 16 bits of the buffer byte address. Word 1 holds the flag byte in bits 15:8 and the high address byte in bits 7:0. Word 2 holds the length. Word 3 holds the status.
- R2: In word 1, bit 15 is the ownership bit (1 = engine owns the slot). When a demand finds this bit clear, the engine sends no byte, writes no memory and raises no done pulse.
- R3: The byte count is the two's-complement negation of length bits 11:0; bits 15:12 are ignored. Exactly that many bytes are sent, with no padding of short frames.
- R4: Bytes are read from consecutive byte addresses starting at {high byte, low word}. The byte at byte address A lies in memory word A>>1: in bits 15:8 when A is even, in bits 7:0 when A is odd.
- R5: While txValid is high and txReady is low, txValid, txData and txLast stay unchanged. txLast is high only with the final byte of a frame.
- R6: After the final byte is accepted, the engine waits for macDone. It then writes status word 3 as follows: bits 9:0 = macTdr, bit 10 = macAbort, bit 11 = macLostCarrier, bit 12 = macLateColl, bit 13 = 0, bit 14 = macUnderflow, bit 15 = missing end-of-packet.
- R7: Exactly one cycle after the status write, the engine writes word 1. The high address byte is kept, and the flag byte is rebuilt as follows:
  - bit 15 (ownership) = 0;
  - bit 14 (error summary) = OR of word-3 bits 10, 11, 12, 14 and 15;
  - bit 12 = 1 if macRetries > 1;
  - bit 11 = 1 if macRetries == 1;
  - bit 10 = macDeferred;
  - bits 9 (start of packet) and 8 (end of packet) keep their values;
  - bit 13 = 0.
- R8: txDone is a single-cycle pulse, raised in the same cycle as the word-1 write.
- R9: A slot whose end-of-packet bit (word 1, bit 8) is clear is still sent in full. It gets status bit 15 and the error summary set.
- R10: After each write-back the index advances. The engine keeps processing slots while their ownership bit is set, and stops at the first slot the host owns.
- R11: The ring holds 2^ringLenWord[15:13] slots and the index wraps to 0 after the last one. ringLenWord bits 12:0 have no effect.
- R12: Reset sets the index to 0 and leaves the engine idle. A demand that arrives while a slot is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ringBase | input | ADDR_W | Word address of slot 0 |
| ringLenWord | input | 16 | Ring length word; bits 15:13 give log2 of slot count |
| txDemand | input | 1 | Poll request pulse |
| memAddr | output | ADDR_W | Memory word address |
| memRe | output | 1 | Memory read; data returns next cycle |
| memWe | output | 1 | Memory write |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data |
| txData | output | 8 | Frame byte |
| txValid | output | 1 | Byte valid |
| txReady | input | 1 | Byte accepted when high with txValid |
| txLast | output | 1 | Final byte of frame |
| macDone | input | 1 | MAC completion pulse for the current frame |
| macTdr | input | 10 | Reflectometry count to record |
| macRetries | input | 5 | Retry count of the frame |
| macAbort | input | 1 | Frame abandoned after excess retries |
| macLostCarrier | input | 1 | Carrier lost during frame |
| macLateColl | input | 1 | Late collision |
| macUnderflow | input | 1 | Data underflow |
| macDeferred | input | 1 | Transmission deferred |
| txDone | output | 1 | One pulse per written-back slot |

## Verification
The hardest case to reach from the ports is an index wrap that is proven by what does *not* happen. To set it up, the ring is shrunk to two slots through the length word, with its low bits filled with ones. A third slot is then placed just past the shortened ring with its ownership bit set: an engine that failed to wrap would send it. A demand issued in the middle of a long, backpressured frame tests that a busy engine ignores polls. A slot without an end-of-packet bit, and MAC status patterns that cover every flag and status bit, check the written-back words bit by bit.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [2:0] {
    SEL_LO,
    SEL_FLAG,
    SEL_LEN,
    SEL_STAT,
    SEL_BUF
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RDFLAG,
    ST_CHKFLAG,
    ST_GETLO,
    ST_GETLEN,
    ST_FETCH,
    ST_LOAD,
    ST_SEND,
    ST_WAITMAC,
    ST_WRSTAT,
    ST_WRFLAG
  } state_e;

  typedef struct packed {
    logic     ldFlag;
    logic     ldLo;
    logic     ldLen;
    logic     ldByte;
    logic     advByte;
    logic     ldStat;
    logic     advIdx;
    logic     wrFlag;
    addrSel_e addrSel;
  } ctrlStrobe_t;

  localparam int WORD_OFS_LO   = 0;
  localparam int WORD_OFS_FLAG = 1;
  localparam int WORD_OFS_LEN  = 2;
  localparam int WORD_OFS_STAT = 3;

endpackage

// File: rtl/txring_dpath.sv
module txring_dpath
  import txring_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int MAX_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [2:0]        ringLog2,
  input  ctrlStrobe_t       strobe,
  input  logic [15:0]       memRdata,
  input  logic [9:0]        macTdr,
  input  logic [4:0]        macRetries,
  input  logic              macAbort,
  input  logic              macLostCarrier,
  input  logic              macLateColl,
  input  logic              macUnderflow,
  input  logic              macDeferred,
  output logic [ADDR_W-1:0] memAddr,
  output logic [15:0]       memWdata,
  output logic [7:0]        txData,
  output logic              ownSeen,
  output logic              countZero,
  output logic              remIsOne
);

  localparam int IDX_W   = MAX_LOG2;
  localparam int BADDR_W = 24;
  localparam int CNT_W   = 12;

  logic [IDX_W-1:0]   idxQ;
  logic [IDX_W-1:0]   sizeMask;
  logic [ADDR_W-1:0]  descBase;
  logic [BADDR_W-1:0] byteAddrQ;
  logic [CNT_W-1:0]   remQ;
  logic [CNT_W-1:0]   lenCount;
  logic [7:0]         hiQ;
  logic [1:0]         stpEnpQ;
  logic [7:0]         byteQ;
  logic [15:0]        statQ;
  logic [7:0]         flagNewQ;
  logic               noEnp;
  logic               errAny;

  always_comb sizeMask = IDX_W'((32'd1 << ringLog2) - 32'd1);

  assign descBase  = ringBase + ADDR_W'({idxQ, 2'b00});
  assign lenCount  = CNT_W'(~memRdata[CNT_W-1:0] + 12'd1);
  assign countZero = (lenCount == '0);
  assign remIsOne  = (remQ == CNT_W'(1));
  assign ownSeen   = memRdata[15];
  assign txData    = byteQ;
  assign noEnp     = ~stpEnpQ[0];
  assign errAny    = macAbort | macLostCarrier | macLateColl | macUnderflow | noEnp;

  always_comb begin
    unique case (strobe.addrSel)
      SEL_LO:   memAddr = descBase + ADDR_W'(WORD_OFS_LO);
      SEL_FLAG: memAddr = descBase + ADDR_W'(WORD_OFS_FLAG);
      SEL_LEN:  memAddr = descBase + ADDR_W'(WORD_OFS_LEN);
      SEL_STAT: memAddr = descBase + ADDR_W'(WORD_OFS_STAT);
      default:  memAddr = ADDR_W'(byteAddrQ >> 1);
    endcase
  end

  assign memWdata = strobe.wrFlag ? {flagNewQ, hiQ} : statQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ      <= '0;
      hiQ       <= '0;
      stpEnpQ   <= '0;
      byteAddrQ <= '0;
      remQ      <= '0;
      byteQ     <= '0;
      statQ     <= '0;
      flagNewQ  <= '0;
    end else begin
      if (strobe.ldFlag) begin
        hiQ     <= memRdata[7:0];
        stpEnpQ <= memRdata[9:8];
      end
      if (strobe.ldLo)   byteAddrQ <= {hiQ, memRdata};
      if (strobe.ldLen)  remQ      <= lenCount;
      if (strobe.ldByte) byteQ     <= byteAddrQ[0] ? memRdata[7:0] : memRdata[15:8];
      if (strobe.advByte) begin
        byteAddrQ <= byteAddrQ + BADDR_W'(1);
        remQ      <= remQ - CNT_W'(1);
      end
      if (strobe.ldStat) begin
        statQ    <= {noEnp, macUnderflow, 1'b0, macLateColl, macLostCarrier, macAbort, macTdr};
        flagNewQ <= {1'b0, errAny, 1'b0, (macRetries > 5'd1), (macRetries == 5'd1),
                     macDeferred, stpEnpQ};
      end
      if (strobe.advIdx) idxQ <= (idxQ + IDX_W'(1)) & sizeMask;
    end
  end

  AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rstN)
    $stable(ringLog2) |-> ((idxQ & ~sizeMask) == '0)); // R11

  AST_REM_NONZERO_SEND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advByte |-> (remQ != '0)); // R3

endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txDemand,
  input  logic        ownSeen,
  input  logic        countZero,
  input  logic        remIsOne,
  input  logic        txReady,
  input  logic        macDone,
  output ctrlStrobe_t strobe,
  output logic        memRe,
  output logic        memWe,
  output logic        txValid,
  output logic        txLast,
  output logic        txDone
);

  state_e stateQ, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSel = SEL_FLAG;
    memRe          = 1'b0;
    memWe          = 1'b0;
    txValid        = 1'b0;
    txLast         = 1'b0;
    txDone         = 1'b0;
    stateNext      = stateQ;
    unique case (stateQ)
      ST_IDLE: if (txDemand) stateNext = ST_RDFLAG;
      ST_RDFLAG: begin
        memRe     = 1'b1;
        stateNext = ST_CHKFLAG;
      end
      ST_CHKFLAG: begin
        if (ownSeen) begin
          strobe.ldFlag  = 1'b1;
          strobe.addrSel = SEL_LO;
          memRe          = 1'b1;
          stateNext      = ST_GETLO;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_GETLO: begin
        strobe.ldLo    = 1'b1;
        strobe.addrSel = SEL_LEN;
        memRe          = 1'b1;
        stateNext      = ST_GETLEN;
      end
      ST_GETLEN: begin
        strobe.ldLen = 1'b1;
        stateNext    = countZero ? ST_WAITMAC : ST_FETCH;
      end
      ST_FETCH: begin
        strobe.addrSel = SEL_BUF;
        memRe          = 1'b1;
        stateNext      = ST_LOAD;
      end
      ST_LOAD: begin
        strobe.ldByte = 1'b1;
        stateNext     = ST_SEND;
      end
      ST_SEND: begin
        txValid = 1'b1;
        txLast  = remIsOne;
        if (txReady) begin
          strobe.advByte = 1'b1;
          stateNext      = remIsOne ? ST_WAITMAC : ST_FETCH;
        end
      end
      ST_WAITMAC: begin
        if (macDone) begin
          strobe.ldStat = 1'b1;
          stateNext     = ST_WRSTAT;
        end
      end
      ST_WRSTAT: begin
        strobe.addrSel = SEL_STAT;
        memWe          = 1'b1;
        stateNext      = ST_WRFLAG;
      end
      ST_WRFLAG: begin
        strobe.addrSel = SEL_FLAG;
        strobe.wrFlag  = 1'b1;
        strobe.advIdx  = 1'b1;
        memWe          = 1'b1;
        txDone         = 1'b1;
        stateNext      = ST_RDFLAG;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_SEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R8

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int MAX_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic [15:0]       ringLenWord,
  input  logic              txDemand,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  input  logic              macDone,
  input  logic [9:0]        macTdr,
  input  logic [4:0]        macRetries,
  input  logic              macAbort,
  input  logic              macLostCarrier,
  input  logic              macLateColl,
  input  logic              macUnderflow,
  input  logic              macDeferred,
  output logic              txDone
);

  ctrlStrobe_t strobe;
  logic        ownSeen;
  logic        countZero;
  logic        remIsOne;
  logic        unusedCfg;

  assign unusedCfg = ^ringLenWord[12:0];

  txring_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .txDemand  (txDemand),
    .ownSeen   (ownSeen),
    .countZero (countZero),
    .remIsOne  (remIsOne),
    .txReady   (txReady),
    .macDone   (macDone),
    .strobe    (strobe),
    .memRe     (memRe),
    .memWe     (memWe),
    .txValid   (txValid),
    .txLast    (txLast),
    .txDone    (txDone)
  );

  txring_dpath #(.ADDR_W(ADDR_W), .MAX_LOG2(MAX_LOG2)) u_dpath (
    .clk            (clk),
    .rstN           (rstN),
    .ringBase       (ringBase),
    .ringLog2       (ringLenWord[15:13]),
    .strobe         (strobe),
    .memRdata       (memRdata),
    .macTdr         (macTdr),
    .macRetries     (macRetries),
    .macAbort       (macAbort),
    .macLostCarrier (macLostCarrier),
    .macLateColl    (macLateColl),
    .macUnderflow   (macUnderflow),
    .macDeferred    (macDeferred),
    .memAddr        (memAddr),
    .memWdata       (memWdata),
    .txData         (txData),
    .ownSeen        (ownSeen),
    .countZero      (countZero),
    .remIsOne       (remIsOne)
  );

  AST_RELEASE_OWN: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (memWe && !memWdata[15])); // R7

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $past(memWe)); // R7

  AST_MEM_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R1

  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> ($stable(txData) && $stable(txLast))); // R5

endmodule

// File: tb/tb_txring_engine.sv
module tb_txring_engine;

  localparam int ADDR_W = 23;
  localparam logic [ADDR_W-1:0] RB = 23'h100;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] ringBase = RB;
  logic [15:0]       ringLenWord = 16'h0000;
  logic              txDemand = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic              memRe, memWe;
  logic [15:0]       memWdata;
  logic [15:0]       memRdata = 16'h0;
  logic [7:0]        txData;
  logic              txValid, txLast, txDone;
  logic              txReady = 1'b0;
  logic              macDone = 1'b0;
  logic [9:0]        mTdr = '0;
  logic [4:0]        mRetries = '0;
  logic              mAbort = 0, mLcar = 0, mLcol = 0, mUflo = 0, mDef = 0;

  always #2.5 clk = ~clk;

  txring_engine #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .ringLenWord(ringLenWord),
    .txDemand(txDemand), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .txData(txData), .txValid(txValid),
    .txReady(txReady), .txLast(txLast), .macDone(macDone), .macTdr(mTdr),
    .macRetries(mRetries), .macAbort(mAbort), .macLostCarrier(mLcar),
    .macLateColl(mLcol), .macUnderflow(mUflo), .macDeferred(mDef), .txDone(txDone)
  );

  logic [15:0] mem [0:4095];
  always @(posedge clk) begin
    if (memWe) mem[memAddr[11:0]] <= memWdata;
    if (memRe) memRdata <= mem[memAddr[11:0]];
  end

  int checks = 0, errors = 0;
  logic [7:0]        cap [0:511];
  logic              capLast [0:511];
  logic [ADDR_W-1:0] wrAddr [0:127];
  int capN = 0, wrN = 0, doneN = 0, holdViol = 0, doneViol = 0;
  logic prevValid = 0, prevReady = 0, prevLast = 0, prevDone = 0;
  logic [7:0] prevData = 0;
  int lastCnt = 0, lastServed = 0, macCnt = 0;
  logic bpOn = 0;
  int rc = 0;

  always @(posedge clk) begin
    if (rstN) begin
      if (txValid && txReady) begin
        cap[capN] <= txData; capLast[capN] <= txLast; capN <= capN + 1;
        if (txLast) lastCnt <= lastCnt + 1;
      end
      if (memWe) begin wrAddr[wrN] <= memAddr; wrN <= wrN + 1; end
      if (txDone) doneN <= doneN + 1;
      if (txDone && (!memWe || prevDone)) doneViol <= doneViol + 1;
      if (prevValid && !prevReady &&
          (!txValid || txData != prevData || txLast != prevLast)) holdViol <= holdViol + 1;
      prevValid <= txValid; prevReady <= txReady; prevData <= txData;
      prevLast <= txLast; prevDone <= txDone;
    end
  end

  always @(negedge clk) begin
    rc <= rc + 1;
    txReady <= bpOn ? (rc % 3 != 1) : 1'b1;
    macDone <= 1'b0;
    if (macCnt != 0) begin
      macCnt <= macCnt - 1;
      if (macCnt == 1) macDone <= 1'b1;
    end else if (lastCnt != lastServed) begin
      lastServed <= lastServed + 1;
      macCnt <= 2;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] dIdx(input int i, input int ofs);
    return 12'(RB + 23'(4 * i + ofs));
  endfunction

  task automatic setDesc(input int i, input logic [23:0] ba, input int n, input logic [7:0] flag);
    mem[dIdx(i, 0)] = ba[15:0];
    mem[dIdx(i, 1)] = {flag, ba[23:16]};
    mem[dIdx(i, 2)] = 16'hF000 | (16'(-n) & 16'h0FFF);
    mem[dIdx(i, 3)] = 16'hDEAD;
  endtask

  task automatic putBytes(input logic [23:0] ba, input int n, input logic [7:0] seed);
    for (int k = 0; k < n; k++) begin
      logic [23:0] a;
      a = ba + 24'(k);
      if (a[0]) mem[a[12:1]][7:0] = seed + 8'(k);
      else      mem[a[12:1]][15:8] = seed + 8'(k);
    end
  endtask

  task automatic checkBytes(input int start, input int n, input logic [7:0] seed, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(cap[start + k] == seed + 8'(k), tag, int'(cap[start + k]), int'(seed + 8'(k)));
      chk(capLast[start + k] == (k == n - 1), {tag, " last"}, int'(capLast[start + k]), int'(k == n - 1));
    end
  endtask

  task automatic demand();
    @(negedge clk) txDemand = 1'b1;
    @(negedge clk) txDemand = 1'b0;
  endtask

  task automatic waitDones(input int target);
    for (int c = 0; c < 5000 && doneN < target; c++) @(negedge clk);
    repeat (30) @(negedge clk);
  endtask

  task automatic setMac(input logic [9:0] tdr, input logic [4:0] rt, input bit ab,
                        input bit lc, input bit col, input bit uf, input bit df);
    mTdr = tdr; mRetries = rt; mAbort = ab; mLcar = lc; mLcol = col; mUflo = uf; mDef = df;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txValid == 0, "R12 reset txValid", int'(txValid), 0);
    chk(txDone == 0, "R12 reset txDone", int'(txDone), 0);
    chk(memWe == 0 && memRe == 0, "R12 reset mem idle", int'({memRe, memWe}), 0);
  endtask

  task automatic t_notOwned();
    setDesc(0, 24'h001001, 5, 8'h03);
    demand();
    repeat (30) @(negedge clk);
    chk(capN == 0, "R2 no bytes", capN, 0);
    chk(wrN == 0, "R2 no writes", wrN, 0);
    chk(doneN == 0, "R2 no done", doneN, 0);
  endtask

  task automatic t_single();
    ringLenWord = 16'h4ABC;
    setDesc(0, 24'h001001, 5, 8'h83);
    putBytes(24'h001001, 5, 8'h50);
    setMac(10'h155, 0, 0, 0, 0, 0, 0);
    bpOn = 1;
    demand();
    waitDones(1);
    chk(doneN == 1, "R8 one done", doneN, 1);
    chk(capN == 5, "R3 count", capN, 5);
    checkBytes(0, 5, 8'h50, "R4 bytes odd start");
    chk(mem[dIdx(0, 3)] == 16'h0155, "R6 status", int'(mem[dIdx(0, 3)]), 16'h0155);
    chk(mem[dIdx(0, 1)] == 16'h0300, "R7 flag", int'(mem[dIdx(0, 1)]), 16'h0300);
    chk(wrAddr[0] == RB + 3, "R7 status first", int'(wrAddr[0]), int'(RB + 3));
    chk(wrAddr[1] == RB + 1, "R7 flag second", int'(wrAddr[1]), int'(RB + 1));
  endtask

  task automatic t_chain();
    setDesc(1, 24'h010401, 3, 8'h83);  putBytes(24'h010401, 3, 8'h20);
    setDesc(2, 24'h002000, 60, 8'h83); putBytes(24'h002000, 60, 8'h40);
    setDesc(3, 24'h003001, 2, 8'h83);  putBytes(24'h003001, 2, 8'h90);
    setMac(10'h000, 0, 0, 0, 0, 0, 0);
    demand();
    waitDones(4);
    chk(doneN == 4, "R10 chain dones", doneN, 4);
    chk(capN == 70, "R3 chain bytes exact", capN, 70);
    checkBytes(5, 3, 8'h20, "R4 high byte addr");
    checkBytes(8, 60, 8'h40, "R3 sixty bytes");
    checkBytes(68, 2, 8'h90, "R10 third slot");
    chk(mem[dIdx(1, 1)] == 16'h0301, "R7 hi byte kept", int'(mem[dIdx(1, 1)]), 16'h0301);
    chk(mem[dIdx(0, 3)] == 16'h0155, "R10 stop at host slot", int'(mem[dIdx(0, 3)]), 16'h0155);
  endtask

  task automatic t_status();
    ringLenWord = 16'h3FFF;
    setDesc(0, 24'h004000, 4, 8'h83); putBytes(24'h004000, 4, 8'hA0);
    setDesc(1, 24'h005000, 6, 8'h03);
    setDesc(2, 24'h006000, 3, 8'h83);
    setMac(10'h3FF, 1, 0, 0, 1, 0, 1);
    demand();
    waitDones(5);
    chk(doneN == 5, "R7 status slot done", doneN, 5);
    checkBytes(70, 4, 8'hA0, "R3 four bytes");
    chk(mem[dIdx(0, 3)] == 16'h13FF, "R6 late coll tdr", int'(mem[dIdx(0, 3)]), 16'h13FF);
    chk(mem[dIdx(0, 1)] == 16'h4F00, "R7 err one def", int'(mem[dIdx(0, 1)]), 16'h4F00);
    setDesc(1, 24'h005000, 6, 8'h83); putBytes(24'h005000, 6, 8'hB0);
    setMac(10'h00A, 3, 1, 1, 0, 1, 0);
    demand();
    waitDones(6);
    chk(doneN == 6, "R11 wrap stops", doneN, 6);
    chk(capN == 80, "R11 no third slot", capN, 80);
    chk(mem[dIdx(1, 3)] == 16'h4C0A, "R6 abort lcar uflo", int'(mem[dIdx(1, 3)]), 16'h4C0A);
    chk(mem[dIdx(1, 1)] == 16'h5300, "R7 err more", int'(mem[dIdx(1, 1)]), 16'h5300);
    chk(mem[dIdx(2, 1)] == 16'h8300, "R11 slot2 untouched", int'(mem[dIdx(2, 1)]), 16'h8300);
    chk(mem[dIdx(2, 3)] == 16'hDEAD, "R11 slot2 status", int'(mem[dIdx(2, 3)]), 16'hDEAD);
  endtask

  task automatic t_noEnp();
    setDesc(0, 24'h006000, 2, 8'h82); putBytes(24'h006000, 2, 8'hC0);
    setMac(10'h001, 0, 0, 0, 0, 0, 0);
    demand();
    waitDones(7);
    checkBytes(80, 2, 8'hC0, "R9 bytes sent");
    chk(mem[dIdx(0, 3)] == 16'h8001, "R9 buff status", int'(mem[dIdx(0, 3)]), 16'h8001);
    chk(mem[dIdx(0, 1)] == 16'h4200, "R9 err flag", int'(mem[dIdx(0, 1)]), 16'h4200);
  endtask

  task automatic t_busyDemand();
    setDesc(1, 24'h007000, 40, 8'h83); putBytes(24'h007000, 40, 8'h10);
    setMac(10'h000, 0, 0, 0, 0, 0, 0);
    demand();
    for (int c = 0; c < 2000 && capN < 92; c++) @(negedge clk);
    demand();
    waitDones(8);
    chk(doneN == 8, "R12 busy demand one done", doneN, 8);
    chk(capN == 122, "R12 busy demand bytes", capN, 122);
    checkBytes(82, 40, 8'h10, "R5 backpressured bytes");
    chk(mem[dIdx(0, 1)] == 16'h4200, "R12 slot0 untouched", int'(mem[dIdx(0, 1)]), 16'h4200);
  endtask

  task automatic t_global();
    chk(holdViol == 0, "R5 hold under backpressure", holdViol, 0);
    chk(doneViol == 0, "R8 done pulse with write", doneViol, 0);
    for (int j = 0; j < wrN / 2; j++)
      chk(wrAddr[2*j][1:0] == 2'd3 && wrAddr[2*j+1][1:0] == 2'd1, "R7 write order",
          int'(wrAddr[2*j]), int'(wrAddr[2*j+1]));
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    repeat (5) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    t_notOwned();
    t_single();
    t_chain();
    t_status();
    t_noEnp();
    t_busyDemand();
    t_global();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule